// File: doc/BRIEF.md
# Masked Semaphore Interrupt Channel

This block carries two independent 16-bit semaphore words between a host and a coprocessor, one word for each direction. The sending side raises flag bits by writing ones to its set register. The receiving side reads the raw word, clears the bits it has handled through its acknowledge register, and blocks bits it does not care about through its mask register.

Each direction produces a summary flag. The flag is high when any pending bit is not masked. An interrupt pulse goes to the receiving side when that flag goes from low to high. Because the summary depends on the mask as well as the word, unmasking a bit that is already pending raises the interrupt without any new set write.

Both register decoders are inside the block. Each side has a simple write strobe with an address and data. Read data is combinational from the address.

Top module: `sem_irq_chan`

## Requirements
- R1: Reset clears both semaphore words and both masks. After reset, both summary outputs and both interrupt outputs are 0, and every register reads 0.
- R2: A write to a set register ORs the written 1 bits into the word of the direction that side sends. The host set register is at address 0x10 and feeds the host-to-coprocessor word. The coprocessor set register is at 0xCC and feeds the coprocessor-to-host word. Bits written as 0 have no effect.
- R3: A write to an acknowledge register clears the written 1 bits in the word that side receives. The coprocessor acknowledge register is at 0xD0 and acts on the host-to-coprocessor word. The host acknowledge register is at 0x18 and acts on the coprocessor-to-host word. Bits written as 0 have no effect.
- R4: When a set and an acknowledge hit the same bit in the same cycle, the bit ends up 1.
- R5: Reads on each side are as follows. The get register returns the raw received word: coprocessor 0xD2, host 0x1C. The mask register reads back the mask: coprocessor 0xCE, host 0x14. Set and acknowledge registers and unmapped addresses read 0.
- R6: Each summary output equals the OR over all bits of (word AND NOT mask) for the direction that side receives. The same value appears at bit 9 of a status word, with all other status bits 0. The coprocessor status word is at 0xD6 and the host status word is at 0x0C.
- R7: A mask write changes the summary output in the cycle right after the write edge, with no semaphore write needed.
- R8: An interrupt output is high for exactly the one cycle in which its summary first reads 1 after reading 0. It stays low while the summary stays 1 and when the summary falls.
- R9: A mask write alone that uncovers a pending bit raises the interrupt.
- R10: Writes to one direction's registers leave the other direction's word, mask, summary and interrupt unchanged. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 8 | Host register address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, combinational |
| c_we | input | 1 | Coprocessor write strobe |
| c_addr | input | 8 | Coprocessor register address |
| c_wdata | input | 16 | Coprocessor write data |
| c_rdata | output | 16 | Coprocessor read data, combinational |
| h_sem_pend | output | 1 | Host summary: unmasked coprocessor-to-host bits pending |
| h_sem_irq | output | 1 | Host interrupt pulse |
| c_sem_pend | output | 1 | Coprocessor summary: unmasked host-to-coprocessor bits pending |
| c_sem_irq | output | 1 | Coprocessor interrupt pulse |

## Verification
The assertions check these properties on every cycle:
- an interrupt is only ever a single-cycle pulse that coincides with a fresh rise of its summary;
- a simultaneous set and acknowledge leaves the set bits high;
- a lone acknowledge clears exactly the bits it names;
- reset empties both words and both masks.

Some behaviours can only be shown by the bench's scenarios:
- the mask uncovering an already pending bit and firing the interrupt with no semaphore traffic;
- the read decode of every address on both sides;
- the lack of any coupling between the two directions.

The bench checks these against a reference model under random traffic.

// File: rtl/sem_irq_chan.sv
module sem_irq_chan #(
  parameter int W       = 16,
  parameter int AW      = 8,
  parameter int ST_BIT  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [W-1:0]  h_wdata,
  output logic [W-1:0]  h_rdata,
  input  logic          c_we,
  input  logic [AW-1:0] c_addr,
  input  logic [W-1:0]  c_wdata,
  output logic [W-1:0]  c_rdata,
  output logic          h_sem_pend,
  output logic          h_sem_irq,
  output logic          c_sem_pend,
  output logic          c_sem_irq
);
  localparam logic [AW-1:0] H_SET  = AW'('h10);
  localparam logic [AW-1:0] H_MASK = AW'('h14);
  localparam logic [AW-1:0] H_ACK  = AW'('h18);
  localparam logic [AW-1:0] H_GET  = AW'('h1C);
  localparam logic [AW-1:0] H_STAT = AW'('h0C);
  localparam logic [AW-1:0] C_SET  = AW'('hCC);
  localparam logic [AW-1:0] C_MASK = AW'('hCE);
  localparam logic [AW-1:0] C_ACK  = AW'('hD0);
  localparam logic [AW-1:0] C_GET  = AW'('hD2);
  localparam logic [AW-1:0] C_STAT = AW'('hD6);

  logic [W-1:0] h2c_q, c2h_q, c_mask_q, h_mask_q;
  logic         h_prev_q, c_prev_q;

  wire h_set  = h_we && h_addr == H_SET;
  wire h_ack  = h_we && h_addr == H_ACK;
  wire h_mskw = h_we && h_addr == H_MASK;
  wire c_set  = c_we && c_addr == C_SET;
  wire c_ack  = c_we && c_addr == C_ACK;
  wire c_mskw = c_we && c_addr == C_MASK;

  wire [W-1:0] h2c_nxt = (h2c_q & ~(c_ack ? c_wdata : '0)) | (h_set ? h_wdata : '0);
  wire [W-1:0] c2h_nxt = (c2h_q & ~(h_ack ? h_wdata : '0)) | (c_set ? c_wdata : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h2c_q    <= '0;
      c2h_q    <= '0;
      c_mask_q <= '0;
      h_mask_q <= '0;
      h_prev_q <= 1'b0;
      c_prev_q <= 1'b0;
    end else begin
      h2c_q    <= h2c_nxt;
      c2h_q    <= c2h_nxt;
      if (c_mskw) c_mask_q <= c_wdata;
      if (h_mskw) h_mask_q <= h_wdata;
      h_prev_q <= h_sem_pend;
      c_prev_q <= c_sem_pend;
    end
  end

  assign c_sem_pend = |(h2c_q & ~c_mask_q);
  assign h_sem_pend = |(c2h_q & ~h_mask_q);
  assign c_sem_irq  = c_sem_pend & ~c_prev_q;
  assign h_sem_irq  = h_sem_pend & ~h_prev_q;

  wire [W-1:0] h_stat = W'(h_sem_pend) << ST_BIT;
  wire [W-1:0] c_stat = W'(c_sem_pend) << ST_BIT;

  always_comb begin
    case (h_addr)
      H_MASK:  h_rdata = h_mask_q;
      H_GET:   h_rdata = c2h_q;
      H_STAT:  h_rdata = h_stat;
      default: h_rdata = '0;
    endcase
  end

  always_comb begin
    case (c_addr)
      C_MASK:  c_rdata = c_mask_q;
      C_GET:   c_rdata = h2c_q;
      C_STAT:  c_rdata = c_stat;
      default: c_rdata = '0;
    endcase
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (h2c_q == '0 && c2h_q == '0 && c_mask_q == '0 && h_mask_q == '0)); // R1
  AST_SET_WINS_H2C: assert property (@(posedge clk) disable iff (!rst_n) (h_set && c_ack) |=> ((h2c_q & $past(h_wdata)) == $past(h_wdata))); // R4
  AST_SET_WINS_C2H: assert property (@(posedge clk) disable iff (!rst_n) (c_set && h_ack) |=> ((c2h_q & $past(c_wdata)) == $past(c_wdata))); // R4
  AST_ACK_CLEARS_H2C: assert property (@(posedge clk) disable iff (!rst_n) (c_ack && !h_set) |=> ((h2c_q & $past(c_wdata)) == '0)); // R3
  AST_ACK_CLEARS_C2H: assert property (@(posedge clk) disable iff (!rst_n) (h_ack && !c_set) |=> ((c2h_q & $past(h_wdata)) == '0)); // R3
  AST_C_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) c_sem_irq |=> !c_sem_irq); // R8
  AST_H_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) h_sem_irq |=> !h_sem_irq); // R8
  AST_C_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(c_sem_irq) |-> c_sem_pend); // R8
  AST_H_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(h_sem_irq) |-> h_sem_pend); // R8
endmodule

// File: tb/sem_irq_chan_tb_top.sv
module sem_irq_chan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_we = 1'b0, c_we = 1'b0;
  logic [7:0] h_addr = '0, c_addr = '0;
  logic [15:0] h_wdata = '0, c_wdata = '0;
  logic [15:0] h_rdata, c_rdata;
  logic h_sem_pend, h_sem_irq, c_sem_pend, c_sem_irq;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_h2c, m_c2h, m_cmask, m_hmask;
  logic m_hprev, m_cprev;

  always #2.5 clk = ~clk;

  sem_irq_chan dut_i (.*);

  function automatic logic [15:0] f_word(logic [15:0] v, logic s, logic [15:0] sd, logic a, logic [15:0] ad);
    return (v & ~(a ? ad : 16'h0)) | (s ? sd : 16'h0);
  endfunction

  function automatic logic [15:0] f_hread(logic [7:0] a);
    case (a)
      8'h14: return m_hmask;
      8'h1C: return m_c2h;
      8'h0C: return {6'h0, |(m_c2h & ~m_hmask), 9'h0};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] f_cread(logic [7:0] a);
    case (a)
      8'hCE: return m_cmask;
      8'hD2: return m_h2c;
      8'hD6: return {6'h0, |(m_h2c & ~m_cmask), 9'h0};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_outs(string req);
    logic cp, hp;
    cp = |(m_h2c & ~m_cmask);
    hp = |(m_c2h & ~m_hmask);
    chk({req, " c_pend"}, 16'(c_sem_pend), 16'(cp));
    chk({req, " h_pend"}, 16'(h_sem_pend), 16'(hp));
    chk({req, " c_irq"}, 16'(c_sem_irq), 16'(cp & ~m_cprev));
    chk({req, " h_irq"}, 16'(h_sem_irq), 16'(hp & ~m_hprev));
    m_cprev = cp;
    m_hprev = hp;
  endtask

  task automatic rd(string req, logic [7:0] ha, logic [7:0] ca);
    h_we = 1'b0; c_we = 1'b0; h_addr = ha; c_addr = ca;
    #0.5;
    chk({req, " h_rdata"}, h_rdata, f_hread(ha));
    chk({req, " c_rdata"}, c_rdata, f_cread(ca));
  endtask

  task automatic step(string req, logic hw, logic [7:0] ha, logic [15:0] hd,
                      logic cw, logic [7:0] ca, logic [15:0] cd);
    @(negedge clk);
    h_we = hw; h_addr = ha; h_wdata = hd;
    c_we = cw; c_addr = ca; c_wdata = cd;
    @(posedge clk);
    #1;
    m_h2c = f_word(m_h2c, hw && ha == 8'h10, hd, cw && ca == 8'hD0, cd);
    m_c2h = f_word(m_c2h, cw && ca == 8'hCC, cd, hw && ha == 8'h18, hd);
    if (cw && ca == 8'hCE) m_cmask = cd;
    if (hw && ha == 8'h14) m_hmask = hd;
    chk_outs(req);
    h_we = 1'b0; c_we = 1'b0;
  endtask

  function automatic logic [7:0] pick_h();
    case ($urandom_range(0, 6))
      0: return 8'h10; 1: return 8'h14; 2: return 8'h18; 3: return 8'h1C;
      4: return 8'h0C; 5: return 8'h10;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  function automatic logic [7:0] pick_c();
    case ($urandom_range(0, 6))
      0: return 8'hCC; 1: return 8'hCE; 2: return 8'hD0; 3: return 8'hD2;
      4: return 8'hD6; 5: return 8'hCC;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  function automatic logic [15:0] sparse();
    return 16'($urandom) & 16'($urandom) & 16'($urandom);
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EA4));
    m_h2c = '0; m_c2h = '0; m_cmask = '0; m_hmask = '0; m_hprev = 0; m_cprev = 0;
    // R1: write during reset must be wiped
    h_we = 1'b1; h_addr = 8'h10; h_wdata = 16'hFFFF;
    c_we = 1'b1; c_addr = 8'hCE; c_wdata = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    h_we = 0; c_we = 0;
    rst_n = 1'b1;
    #0.5;
    chk_outs("R1");
    rd("R1 get", 8'h1C, 8'hD2);
    rd("R1 mask", 8'h14, 8'hCE);

    // R2 set ORs, R8 irq pulse once
    step("R2 R8", 1, 8'h10, 16'h0005, 0, 8'h00, 16'h0);
    rd("R2", 8'h00, 8'hD2);
    step("R2 R8 hold", 1, 8'h10, 16'h0100, 0, 8'h00, 16'h0);
    rd("R2 or", 8'h00, 8'hD2);
    // R3 ack clears only named bits
    step("R3", 0, 8'h00, 16'h0, 1, 8'hD0, 16'h0104);
    rd("R3", 8'h00, 8'hD2);
    // R6 status word
    rd("R6 status", 8'h0C, 8'hD6);
    // R7 R9: mask pending bit then unmask -> irq
    step("R7 mask", 0, 8'h00, 16'h0, 1, 8'hCE, 16'h0001);
    step("R7 R9 unmask", 0, 8'h00, 16'h0, 1, 8'hCE, 16'h0000);
    rd("R9", 8'h00, 8'hD6);
    // R4 set wins on same bit
    step("R4", 1, 8'h10, 16'h00F0, 1, 8'hD0, 16'h00FF);
    rd("R4", 8'h00, 8'hD2);
    step("R4 c2h", 1, 8'h18, 16'hFFFF, 1, 8'hCC, 16'h8001);
    rd("R4 c2h", 8'h1C, 8'h00);
    // R5 SET/ACK read zero
    rd("R5", 8'h10, 8'hCC);
    rd("R5", 8'h18, 8'hD0);
    // R10: unmapped writes do nothing, directions independent
    step("R10", 1, 8'h55, 16'hFFFF, 1, 8'h3C, 16'hFFFF);
    rd("R10", 8'h1C, 8'hD2);
    step("R10 host mask", 1, 8'h14, 16'hFFFF, 0, 8'h00, 16'h0);
    rd("R10", 8'h14, 8'hCE);
    rd("R10", 8'h0C, 8'hD6);

    for (int i = 0; i < 3000; i++) begin
      step("R2 R3 R6 R8 R10", $urandom_range(0, 1) == 1, pick_h(), sparse(),
           $urandom_range(0, 1) == 1, pick_c(), sparse());
      rd("R5 R6", pick_h(), pick_c());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule